// File: doc/BRIEF.md
# Return Address Stack with Shadow Register Save

This block keeps the return addresses of a small processor core. A call, or an explicit push instruction, raises the pointer and stores the current program counter as the new top entry. A return, or an explicit pop instruction, lowers the pointer so that the entry pushed before becomes the top again. Software can overwrite the top entry through three byte lanes (low, high, upper) and always sees it on `tos_o`. The block flags a push into a full stack and a pop from an empty one. Each flag is sticky. A configuration input decides whether such an event also asks for a device reset.

A separate single-entry shadow store captures status, working register and bank select on interrupt entry or on a fast call. A fast return pops the return address and raises a restore strobe in the same cycle, with the saved values on the shadow outputs. The core does the instruction decode and keeps the program counter. It hands this block plain strobes and the PC. No data path here carries back-pressure, so every pin is a plain level or strobe without a valid/ready pair. A strobe is acted on in the cycle it is high.

Top module: `call_return_stack`

## Requirements
- R1: After reset the pointer is 0 and `tos_o` is 0. Both flags, `rst_req_o` and `restore_o` are low, and all three shadow outputs are 0.
- R2: A push with a pointer below 31 raises the pointer by one at the next edge, and `tos_o` then shows the `pc_i` of the push cycle. Pointer value n means n entries are held.
- R3: A pop (`pop_i` or `fast_ret_i`) with a nonzero pointer lowers it by one at the next edge, and the previously pushed entry becomes the top. During the pop cycle `tos_o` shows the address being returned to.
- R4: A push while the pointer is 31 changes no entry and leaves the pointer at 31. It sets the full flag at the next edge.
- R5: A pop while the pointer is 0 leaves the pointer at 0 and returns address 0. It sets the underflow flag at the next edge.
- R6: Each flag stays set until its clear strobe (`clr_full_i`, `clr_unf_i`) or reset. A full or underflow event in the same cycle as its clear strobe leaves the flag set.
- R7: `rst_req_o` is a one-cycle pulse in the cycle after a full or underflow event. It pulses only if `ovf_rst_en_i` was high in the event cycle. The flags are set regardless of `ovf_rst_en_i`.
- R8: `tos_we_i` bit 0 writes `tos_wdata_i` into bits 7:0 of the top entry, bit 1 into bits 15:8, and bit 2 into bits 20:16 (low 5 data bits). Such a write is ignored while the pointer is 0 and in any cycle with a push or pop.
- R9: `push_i` and a pop request in the same cycle perform the push only; the pop request is ignored.
- R10: `fast_save_i` loads `status_i`, `wreg_i` and `bank_i` into the shadow store at the edge. The shadow outputs change at no other time.
- R11: `fast_ret_i` pops like R3 and drives `restore_o` high in that same cycle, with the saved values on the shadow outputs. A save in that same cycle takes effect only after it, so the restore sees the older contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| pc_i | input | 21 | Program counter value to push |
| push_i | input | 1 | Call or push instruction strobe |
| pop_i | input | 1 | Return or pop instruction strobe |
| fast_save_i | input | 1 | Interrupt entry or fast call: capture shadow registers |
| fast_ret_i | input | 1 | Fast return: pop plus shadow restore |
| status_i | input | 8 | Status register to shadow |
| wreg_i | input | 8 | Working register to shadow |
| bank_i | input | 8 | Bank select register to shadow |
| ovf_rst_en_i | input | 1 | Request reset on full or underflow |
| tos_we_i | input | 3 | Byte lane write strobes {upper, high, low} for the top entry |
| tos_wdata_i | input | 8 | Byte written to the selected lanes |
| clr_full_i | input | 1 | Software clear of the full flag |
| clr_unf_i | input | 1 | Software clear of the underflow flag |
| tos_o | output | 21 | Current top entry, 0 when empty |
| ptr_o | output | 5 | Number of held entries |
| full_o | output | 1 | Sticky full flag |
| unf_o | output | 1 | Sticky underflow flag |
| rst_req_o | output | 1 | One-cycle device reset request |
| restore_o | output | 1 | Shadow restore strobe |
| status_o | output | 8 | Shadowed status |
| wreg_o | output | 8 | Shadowed working register |
| bank_o | output | 8 | Shadowed bank select |

## Verification
Several functions can land in the same cycle. A software byte write can meet a push or a pop. A push can meet a pop. A full or underflow event can meet its own clear strobe. A fast save can meet a fast return. The bench provokes each of these on purpose and also mixes them in a long stretch of random strobes. Its behavioural model applies the stated priorities: the stack operation beats the byte write, the push beats the pop, the event beats the clear, and the restore reads the old shadow. Every clock, it compares the model against the top entry, the pointer, both flags, the reset request and the shadow outputs.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  parameter int unsigned REG_W = 8;

  typedef struct packed {
    logic [REG_W-1:0] status;
    logic [REG_W-1:0] wreg;
    logic [REG_W-1:0] bank;
  } shadow_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/rstk_ptr_ctrl.sv
module rstk_ptr_ctrl
  import rstk_pkg::*;
#(
  parameter int unsigned DEPTH = 31,
  parameter int unsigned PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             clr_full_i,
  input  logic             clr_unf_i,
  input  logic             ovf_rst_en_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             push_en_o,
  output logic [PTR_W-1:0] push_idx_o,
  output logic             sw_ok_o,
  output logic             full_o,
  output logic             unf_o,
  output logic             rst_req_o
);
  localparam logic [PTR_W-1:0] TOP_IDX = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] ONE     = PTR_W'(1);

  logic [PTR_W-1:0] ptr_q;
  logic             full_q, unf_q, req_q;
  stk_op_e          op;
  logic             at_top, at_bottom, full_evt, unf_evt;

  // push has priority over any pop request
  always_comb begin
    if (push_i)      op = OP_PUSH;
    else if (pop_i)  op = OP_POP;
    else             op = OP_NONE;
  end

  assign at_top    = (ptr_q == TOP_IDX);
  assign at_bottom = (ptr_q == '0);
  assign full_evt  = (op == OP_PUSH) && at_top;
  assign unf_evt   = (op == OP_POP) && at_bottom;

  assign push_en_o  = (op == OP_PUSH) && !at_top;
  assign push_idx_o = ptr_q + ONE;
  assign sw_ok_o    = (op == OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      full_q <= 1'b0;
      unf_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      case (op)
        OP_PUSH: if (!at_top)    ptr_q <= ptr_q + ONE;
        OP_POP:  if (!at_bottom) ptr_q <= ptr_q - ONE;
        default: ptr_q <= ptr_q;
      endcase
      full_q <= full_evt | (full_q & ~clr_full_i);
      unf_q  <= unf_evt  | (unf_q  & ~clr_unf_i);
      req_q  <= ovf_rst_en_i & (full_evt | unf_evt);
    end
  end

  assign ptr_o     = ptr_q;
  assign full_o    = full_q;
  assign unf_o     = unf_q;
  assign rst_req_o = req_q;

  assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= TOP_IDX);

  assert_pop_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && ptr_q != '0) |=> ptr_q == $past(ptr_q) - ONE);

  assert_full_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && ptr_q == TOP_IDX) |=> (ptr_q == TOP_IDX) && full_q);

  assert_unf_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && ptr_q == '0) |=> (ptr_q == '0) && unf_q);

  assert_full_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !clr_full_i) |=> full_q);

  assert_unf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_q && !clr_unf_i) |=> unf_q);

  assert_req_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(ovf_rst_en_i));

  assert_push_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && ptr_q != TOP_IDX) |=> ptr_q == $past(ptr_q) + ONE);
endmodule

// File: rtl/rstk_store.sv
module rstk_store #(
  parameter int unsigned DEPTH = 31,
  parameter int unsigned AW    = 21,
  parameter int unsigned PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en_i,
  input  logic [PTR_W-1:0] push_idx_i,
  input  logic [AW-1:0]    pc_i,
  input  logic             sw_ok_i,
  input  logic [PTR_W-1:0] rd_idx_i,
  input  logic [2:0]       lane_we_i,
  input  logic [7:0]       lane_data_i,
  output logic [AW-1:0]    top_o
);
  localparam int unsigned UPW = AW - 16;

  logic [AW-1:0] ent [0:DEPTH];

  for (genvar k = 0; k <= DEPTH; k++) begin : g_ent
    if (k == 0) begin : g_empty
      // slot 0 stands for the empty stack and always reads 0
      assign ent[k] = '0;
    end else begin : g_slot
      logic [AW-1:0] val_q;
      logic          sel_push, sel_sw;
      assign sel_push = push_en_i && (push_idx_i == PTR_W'(k));
      assign sel_sw   = sw_ok_i && (rd_idx_i == PTR_W'(k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q <= '0;
        end else if (sel_push) begin
          val_q <= pc_i;
        end else if (sel_sw) begin
          if (lane_we_i[0]) val_q[7:0]   <= lane_data_i;
          if (lane_we_i[1]) val_q[15:8]  <= lane_data_i;
          if (lane_we_i[2]) val_q[AW-1:16] <= lane_data_i[UPW-1:0];
        end
      end
      assign ent[k] = val_q;
    end
  end

  assign top_o = ent[rd_idx_i];
endmodule

// File: rtl/rstk_shadow.sv
module rstk_shadow
  import rstk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    save_i,
  input  shadow_t d_i,
  output shadow_t q_o
);
  shadow_t q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (save_i)  q <= d_i;
  end

  assign q_o = q;

  assert_save_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
    save_i |=> q == $past(d_i));

  assert_hold_no_save_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !save_i |=> $stable(q));
endmodule

// File: rtl/call_return_stack.sv
module call_return_stack
  import rstk_pkg::*;
#(
  parameter int unsigned DEPTH = 31,
  parameter int unsigned AW    = 21,
  localparam int unsigned PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    pc_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             fast_save_i,
  input  logic             fast_ret_i,
  input  logic [REG_W-1:0] status_i,
  input  logic [REG_W-1:0] wreg_i,
  input  logic [REG_W-1:0] bank_i,
  input  logic             ovf_rst_en_i,
  input  logic [2:0]       tos_we_i,
  input  logic [7:0]       tos_wdata_i,
  input  logic             clr_full_i,
  input  logic             clr_unf_i,
  output logic [AW-1:0]    tos_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             full_o,
  output logic             unf_o,
  output logic             rst_req_o,
  output logic             restore_o,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] wreg_o,
  output logic [REG_W-1:0] bank_o
);
  localparam logic [PTR_W-1:0] TOP_IDX = PTR_W'(DEPTH);

  logic             pop_req, push_en, sw_ok;
  logic [PTR_W-1:0] push_idx, ptr;
  shadow_t          shd_d, shd_q;

  assign pop_req = pop_i | fast_ret_i;

  rstk_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (push_i),
    .pop_i        (pop_req),
    .clr_full_i   (clr_full_i),
    .clr_unf_i    (clr_unf_i),
    .ovf_rst_en_i (ovf_rst_en_i),
    .ptr_o        (ptr),
    .push_en_o    (push_en),
    .push_idx_o   (push_idx),
    .sw_ok_o      (sw_ok),
    .full_o       (full_o),
    .unf_o        (unf_o),
    .rst_req_o    (rst_req_o)
  );

  rstk_store #(.DEPTH(DEPTH), .AW(AW), .PTR_W(PTR_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_en_i   (push_en),
    .push_idx_i  (push_idx),
    .pc_i        (pc_i),
    .sw_ok_i     (sw_ok),
    .rd_idx_i    (ptr),
    .lane_we_i   (tos_we_i),
    .lane_data_i (tos_wdata_i),
    .top_o       (tos_o)
  );

  assign shd_d = '{status: status_i, wreg: wreg_i, bank: bank_i};

  rstk_shadow u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .save_i (fast_save_i),
    .d_i    (shd_d),
    .q_o    (shd_q)
  );

  assign ptr_o     = ptr;
  assign restore_o = fast_ret_i;
  assign status_o  = shd_q.status;
  assign wreg_o    = shd_q.wreg;
  assign bank_o    = shd_q.bank;

  assert_push_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && ptr != TOP_IDX) |=> tos_o == $past(pc_i));

  assert_full_keeps_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && ptr == TOP_IDX) |=> $stable(tos_o));

  assert_empty_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == '0) |-> tos_o == '0);

  assert_lane_ignored_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == '0 && !push_i) |=> tos_o == '0);
endmodule

// File: tb/call_return_stack_test.sv
module call_return_stack_test;
  localparam int AW = 21;
  localparam int DEPTH = 31;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] pc_i = '0;
  logic push_i = 0, pop_i = 0, fast_save_i = 0, fast_ret_i = 0;
  logic [7:0] status_i = 0, wreg_i = 0, bank_i = 0;
  logic ovf_rst_en_i = 0;
  logic [2:0] tos_we_i = 0;
  logic [7:0] tos_wdata_i = 0;
  logic clr_full_i = 0, clr_unf_i = 0;
  logic [AW-1:0] tos_o;
  logic [4:0] ptr_o;
  logic full_o, unf_o, rst_req_o, restore_o;
  logic [7:0] status_o, wreg_o, bank_o;

  call_return_stack uut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [AW-1:0] q[$];
  bit m_full = 0, m_unf = 0, m_req = 0;
  logic [7:0] m_st = 0, m_w = 0, m_b = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] m_top();
    return (q.size() == 0) ? '0 : q[q.size()-1];
  endfunction

  task automatic check_state(string tag);
    chk(tag, "ptr", ptr_o, q.size());
    chk(tag, "tos", tos_o, m_top());
    chk(tag, "full", full_o, m_full);
    chk(tag, "unf", unf_o, m_unf);
    chk(tag, "rst_req", rst_req_o, m_req);
    chk(tag, "status", status_o, m_st);
    chk(tag, "wreg", wreg_o, m_w);
    chk(tag, "bank", bank_o, m_b);
  endtask

  task automatic idle();
    push_i = 0; pop_i = 0; fast_save_i = 0; fast_ret_i = 0;
    tos_we_i = 0; clr_full_i = 0; clr_unf_i = 0;
  endtask

  // one clock with the inputs currently driven; model advances alongside
  task automatic cyc(string tag);
    bit psh, pp, fev, uev;
    logic [AW-1:0] t;
    #1;
    chk(tag, "restore", restore_o, fast_ret_i);
    chk(tag, "ret_addr", tos_o, m_top());
    chk(tag, "shadow_at_restore", {status_o, wreg_o, bank_o}, {m_st, m_w, m_b});
    psh = push_i;
    pp  = (pop_i | fast_ret_i) & ~push_i;
    fev = psh && q.size() == DEPTH;
    uev = pp && q.size() == 0;
    if (!psh && !pp && q.size() > 0) begin
      t = q[q.size()-1];
      if (tos_we_i[0]) t[7:0] = tos_wdata_i;
      if (tos_we_i[1]) t[15:8] = tos_wdata_i;
      if (tos_we_i[2]) t[20:16] = tos_wdata_i[4:0];
      q[q.size()-1] = t;
    end
    if (psh && !fev) q.push_back(pc_i);
    if (pp && q.size() > 0) void'(q.pop_back());
    m_full = fev | (m_full & ~clr_full_i);
    m_unf  = uev | (m_unf & ~clr_unf_i);
    m_req  = ovf_rst_en_i & (fev | uev);
    if (fast_save_i) begin m_st = status_i; m_w = wreg_i; m_b = bank_i; end
    @(posedge clk);
    #1;
    check_state(tag);
    idle();
  endtask

  task automatic do_push(logic [AW-1:0] a, string tag);
    pc_i = a; push_i = 1; cyc(tag);
  endtask

  task automatic do_pop(string tag);
    pop_i = 1; cyc(tag);
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check_state("R1");
    chk("R1", "restore", restore_o, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R2 basic pushes
    for (int i = 0; i < 5; i++) do_push(AW'(21'h1000 + i * 21'h0F0F1), "R2");
    // R3 pops
    do_pop("R3");
    do_pop("R3");
    // R8 byte lane writes on top
    tos_we_i = 3'b001; tos_wdata_i = 8'hA5; cyc("R8");
    tos_we_i = 3'b010; tos_wdata_i = 8'h3C; cyc("R8");
    tos_we_i = 3'b100; tos_wdata_i = 8'hFF; cyc("R8");
    tos_we_i = 3'b111; tos_wdata_i = 8'h12; cyc("R8");
    // R8 write ignored alongside push and pop
    tos_we_i = 3'b111; tos_wdata_i = 8'h77; pc_i = 21'h0ABCD; push_i = 1; cyc("R8");
    tos_we_i = 3'b111; tos_wdata_i = 8'h66; pop_i = 1; cyc("R8");
    // R9 push and pop together
    pc_i = 21'h1F00F; push_i = 1; pop_i = 1; cyc("R9");
    pc_i = 21'h12345; push_i = 1; fast_ret_i = 1; cyc("R9");
    // R4 fill then overflow with reset request disabled
    while (q.size() < DEPTH) do_push(AW'(21'h08000 + q.size()), "R4");
    do_push(21'h1DEAD, "R4");
    do_push(21'h1BEEF, "R4");
    // R6 clear collides with event, then plain clear
    pc_i = 21'h00111; push_i = 1; clr_full_i = 1; cyc("R6");
    cyc("R6");
    clr_full_i = 1; cyc("R6");
    // R7 enabled request on full
    ovf_rst_en_i = 1;
    do_push(21'h00222, "R7");
    cyc("R7");
    // R5 drain then underflow
    ovf_rst_en_i = 0;
    while (q.size() > 0) do_pop("R3");
    do_pop("R5");
    tos_we_i = 3'b111; tos_wdata_i = 8'h99; cyc("R8");
    ovf_rst_en_i = 1;
    fast_ret_i = 1; cyc("R7");
    clr_unf_i = 1; cyc("R6");
    ovf_rst_en_i = 0;
    // R10 / R11 shadow store
    status_i = 8'h1A; wreg_i = 8'h2B; bank_i = 8'h3C; fast_save_i = 1; cyc("R10");
    status_i = 8'hEE; wreg_i = 8'hDD; bank_i = 8'hCC; cyc("R10");
    do_push(21'h0C0DE, "R11");
    fast_ret_i = 1; cyc("R11");
    do_push(21'h05555, "R11");
    status_i = 8'h44; wreg_i = 8'h55; bank_i = 8'h66; fast_save_i = 1; fast_ret_i = 1; cyc("R11");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      pc_i = AW'($urandom);
      push_i = (r < 40);
      pop_i = (r >= 35 && r < 70);
      fast_ret_i = (r >= 90);
      fast_save_i = ($urandom_range(0, 7) == 0);
      status_i = 8'($urandom); wreg_i = 8'($urandom); bank_i = 8'($urandom);
      tos_we_i = 3'($urandom); tos_wdata_i = 8'($urandom);
      clr_full_i = ($urandom_range(0, 15) == 0);
      clr_unf_i = ($urandom_range(0, 15) == 0);
      ovf_rst_en_i = $urandom_range(0, 1) == 1;
      cyc("R2");
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end
endmodule